// File: doc/BRIEF.md
# Serial Audio Port Serializer

This block is the serial side of an audio codec's data path. It always acts as the master of the link and generates its own bit clock and frame sync. On each sample-rate tick it sends one 32-bit frame. The frame holds a 16-bit left slot followed by a 16-bit right slot. At the same time it shifts in a matching frame from the serial input and hands the two received words to the converter side as parallel samples.

Samples may be 16, 8 or 4 bits wide (the 4-bit case carries compressed ADPCM codes). They always travel MSB first at the start of their slot, and every position after the last data bit is sent as zero. One frame layout therefore serves all sizes. A mono setting silences the outgoing right slot and sends the received left word to both outputs. Enable, frame-sync style, sample size and mono are sampled from the inputs only while the configuration-gate input is high. When the port is disabled, all three serial lines stay low.

Top module: `aud_serial_port`

## Requirements
- R1: After reset, fsync, sclk, sdout and dac_valid are low, dac_left and dac_right are zero, and the port is disabled.
- R2: While the port is disabled, fsync, sclk and sdout stay low, rate_tick is ignored, and dac_valid never rises.
- R3: cfg_enable, cfg_format, cfg_size and cfg_mono are captured only on clock edges where cfg_mce is high. At all other edges the previously captured values are kept.
- R4: A rate_tick while enabled and idle starts a frame of 32 bit periods, each 2*HALF_DIV clocks long. sclk is low for the first half of each bit period and high for the second half. A rate_tick during a frame, other than in its final clock, is ignored.
- R5: sdout carries the left slot in bit periods 0..15, then the right slot in 16..31, each MSB first. sdout changes only when sclk goes low or is already low.
- R6: cfg_size selects the sample width, taken from the low end of the input sample: 0 = 16 bits, 1 = 8 bits from bits [7:0], 2 = 4 bits from bits [3:0], 3 = treated as 16 bits. The sample fills the first slot positions and the rest of the slot is zero.
- R7: cfg_format 0 and 3 drive fsync high for bit periods 0..15 and low for 16..31. Format 1 drives it high only in bit period 31, just before the next left MSB. Format 2 drives it high only in bit period 0.
- R8: sdin is sampled where sclk rises. Bit periods 0..15 form dac_left and 16..31 form dac_right, MSB first. Positions beyond the selected sample width are returned as zero.
- R9: dac_valid is high for exactly one clock, in the cycle after the clock edge that ends bit period 31. dac_left and dac_right change only at that edge.
- R10: With mono set, the outgoing right slot is all zeros and dac_right equals dac_left.
- R11: A rate_tick in the final clock of a frame starts the next frame with no gap, and the bit clock runs on without a break.
- R12: Clearing the enable in the middle of a frame forces fsync, sclk and sdout low within two clocks after the gated write, and that frame produces no dac_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mce | input | 1 | Configuration gate; settings are captured while high |
| cfg_enable | input | 1 | Port enable setting |
| cfg_format | input | 2 | Frame-sync style setting |
| cfg_size | input | 2 | Sample width setting |
| cfg_mono | input | 1 | Mono setting |
| rate_tick | input | 1 | Sample-rate tick, one clock wide |
| adc_left | input | 16 | Left sample to transmit, low-aligned |
| adc_right | input | 16 | Right sample to transmit, low-aligned |
| sdin | input | 1 | Serial data in |
| fsync | output | 1 | Frame sync |
| sclk | output | 1 | Serial bit clock |
| sdout | output | 1 | Serial data out |
| dac_left | output | 16 | Received left word |
| dac_right | output | 16 | Received right word |
| dac_valid | output | 1 | One-clock strobe marking new received words |

## Verification
The assertions take for granted that rate_tick is a single-clock pulse and that ticks are at least one full frame apart. The one-clock valid rule depends on that spacing. They also assume settings are rewritten only between frames, so the registered mono value matches the one used when a frame completes. The bench issues each tick for one clock, waits for the previous frame to end before ticking again, and performs every gated write while the port is idle. The only exception is the deliberate mid-frame disable.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int SLOT_W     = 16;
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        FMT_LEVEL   = 2'd0,
        FMT_EARLY   = 2'd1,
        FMT_ALIGNED = 2'd2,
        FMT_RSVD    = 2'd3
    } frame_fmt_e;

    typedef enum logic [1:0] {
        SZ_16   = 2'd0,
        SZ_8    = 2'd1,
        SZ_4    = 2'd2,
        SZ_RSVD = 2'd3
    } word_size_e;

    typedef struct packed {
        logic       enable;
        frame_fmt_e fmt;
        word_size_e size;
        logic       mono;
    } port_cfg_t;

    // Move a low-aligned sample to the top of its slot, zero filling behind it.
    function automatic logic [SLOT_W-1:0] place_sample(word_size_e sz, logic [SLOT_W-1:0] s);
        case (sz)
            SZ_8:    return s << (SLOT_W - 8);
            SZ_4:    return s << (SLOT_W - 4);
            default: return s;
        endcase
    endfunction

    // Zero every slot position behind the last data bit of a received word.
    function automatic logic [SLOT_W-1:0] trim_word(word_size_e sz, logic [SLOT_W-1:0] w);
        case (sz)
            SZ_8:    return w & ({SLOT_W{1'b1}} << (SLOT_W - 8));
            SZ_4:    return w & ({SLOT_W{1'b1}} << (SLOT_W - 4));
            default: return w;
        endcase
    endfunction

    // Frame-sync level for a given bit period.
    function automatic logic sync_level(frame_fmt_e f, logic [BIT_IDX_W-1:0] idx);
        case (f)
            FMT_EARLY:   return idx == BIT_IDX_W'(FRAME_BITS - 1);
            FMT_ALIGNED: return idx == '0;
            default:     return idx < BIT_IDX_W'(SLOT_W);
        endcase
    endfunction

endpackage

// File: rtl/asp_cfg_reg.sv
module asp_cfg_reg
    import asp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mce,
    input  port_cfg_t wr_cfg,
    output port_cfg_t cfg
);

    typedef struct packed {
        port_cfg_t cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mce) begin
            st_d.cfg = wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg.enable <= 1'b0;
            st_q.cfg.fmt    <= FMT_LEVEL;
            st_q.cfg.size   <= SZ_16;
            st_q.cfg.mono   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

endmodule

// File: rtl/asp_bitclk.sv
module asp_bitclk
    import asp_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 tick,
    output logic                 busy,
    output logic                 sclk,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output logic                 start_p,
    output logic                 rise_p,
    output logic                 fall_p,
    output logic                 last_fall_p
);

    localparam int                   PERIOD   = 2 * HALF_DIV;
    localparam int                   DIV_W    = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [DIV_W-1:0]     DIV_LAST = DIV_W'(PERIOD - 1);
    localparam logic [DIV_W-1:0]     DIV_RISE = DIV_W'(HALF_DIV - 1);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                 busy;
        logic                 sclk;
        logic [DIV_W-1:0]     div;
        logic [BIT_IDX_W-1:0] bit_idx;
    } clk_state_t;

    clk_state_t st_d, st_q;

    assign rise_p      = st_q.busy && (st_q.div == DIV_RISE);
    assign fall_p      = st_q.busy && (st_q.div == DIV_LAST);
    assign last_fall_p = fall_p && (st_q.bit_idx == LAST_BIT);
    assign start_p     = enable && tick && (!st_q.busy || last_fall_p);

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (start_p) begin
            st_d.busy    = 1'b1;
            st_d.sclk    = 1'b0;
            st_d.div     = '0;
            st_d.bit_idx = '0;
        end else if (st_q.busy) begin
            if (st_q.div == DIV_LAST) begin
                st_d.div  = '0;
                st_d.sclk = 1'b0;
                if (st_q.bit_idx == LAST_BIT) begin
                    st_d.busy    = 1'b0;
                    st_d.bit_idx = '0;
                end else begin
                    st_d.bit_idx = st_q.bit_idx + 1'b1;
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
                if (st_q.div == DIV_RISE) begin
                    st_d.sclk = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign sclk    = st_q.sclk;
    assign bit_idx = st_q.bit_idx;

endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  frame_fmt_e           fmt,
    input  word_size_e           size,
    input  logic                 mono,
    input  logic                 start_p,
    input  logic                 fall_p,
    input  logic                 last_fall_p,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    input  logic [SLOT_W-1:0]    smp_left,
    input  logic [SLOT_W-1:0]    smp_right,
    output logic                 sdout,
    output logic                 fsync
);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic                  sdout;
        logic                  fsync;
    } tx_state_t;

    tx_state_t             st_d, st_q;
    logic [FRAME_BITS-1:0] frame_word;
    logic [BIT_IDX_W-1:0]  next_idx;

    assign frame_word = {place_sample(size, smp_left),
                         mono ? {SLOT_W{1'b0}} : place_sample(size, smp_right)};
    assign next_idx   = bit_idx + 1'b1;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (start_p) begin
            st_d.sdout = frame_word[FRAME_BITS-1];
            st_d.shreg = frame_word << 1;
            st_d.fsync = sync_level(fmt, '0);
        end else if (last_fall_p) begin
            st_d = '0;
        end else if (fall_p) begin
            st_d.sdout = st_q.shreg[FRAME_BITS-1];
            st_d.shreg = st_q.shreg << 1;
            st_d.fsync = sync_level(fmt, next_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdout = st_q.sdout;
    assign fsync = st_q.fsync;

endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  word_size_e        size,
    input  logic              mono,
    input  logic              rise_p,
    input  logic              last_fall_p,
    input  logic              sdin,
    output logic [SLOT_W-1:0] dac_left,
    output logic [SLOT_W-1:0] dac_right,
    output logic              dac_valid
);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic [SLOT_W-1:0]     left;
        logic [SLOT_W-1:0]     right;
        logic                  valid;
    } rx_state_t;

    rx_state_t         st_d, st_q;
    logic [SLOT_W-1:0] got_left;
    logic [SLOT_W-1:0] got_right;

    assign got_left  = trim_word(size, st_q.shreg[FRAME_BITS-1:SLOT_W]);
    assign got_right = trim_word(size, st_q.shreg[SLOT_W-1:0]);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (!enable) begin
            st_d.shreg = '0;
        end else begin
            if (rise_p) begin
                st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], sdin};
            end
            if (last_fall_p) begin
                st_d.left  = got_left;
                st_d.right = mono ? got_left : got_right;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_left  = st_q.left;
    assign dac_right = st_q.right;
    assign dac_valid = st_q.valid;

endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
    import asp_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_mce,
    input  logic        cfg_enable,
    input  logic [1:0]  cfg_format,
    input  logic [1:0]  cfg_size,
    input  logic        cfg_mono,
    input  logic        rate_tick,
    input  logic [15:0] adc_left,
    input  logic [15:0] adc_right,
    input  logic        sdin,
    output logic        fsync,
    output logic        sclk,
    output logic        sdout,
    output logic [15:0] dac_left,
    output logic [15:0] dac_right,
    output logic        dac_valid
);

    port_cfg_t            wr_cfg;
    port_cfg_t            cur_cfg;
    logic                 en_w;
    logic                 mono_w;
    logic                 frame_busy;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic                 start_p;
    logic                 rise_p;
    logic                 fall_p;
    logic                 last_fall_p;

    assign wr_cfg.enable = cfg_enable;
    assign wr_cfg.fmt    = frame_fmt_e'(cfg_format);
    assign wr_cfg.size   = word_size_e'(cfg_size);
    assign wr_cfg.mono   = cfg_mono;

    assign en_w   = cur_cfg.enable;
    assign mono_w = cur_cfg.mono;

    asp_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .mce    (cfg_mce),
        .wr_cfg (wr_cfg),
        .cfg    (cur_cfg)
    );

    asp_bitclk #(.HALF_DIV(HALF_DIV)) u_bitclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (en_w),
        .tick        (rate_tick),
        .busy        (frame_busy),
        .sclk        (sclk),
        .bit_idx     (bit_idx),
        .start_p     (start_p),
        .rise_p      (rise_p),
        .fall_p      (fall_p),
        .last_fall_p (last_fall_p)
    );

    asp_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (en_w),
        .fmt         (cur_cfg.fmt),
        .size        (cur_cfg.size),
        .mono        (mono_w),
        .start_p     (start_p),
        .fall_p      (fall_p),
        .last_fall_p (last_fall_p),
        .bit_idx     (bit_idx),
        .smp_left    (adc_left),
        .smp_right   (adc_right),
        .sdout       (sdout),
        .fsync       (fsync)
    );

    asp_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (en_w),
        .size        (cur_cfg.size),
        .mono        (mono_w),
        .rise_p      (rise_p),
        .last_fall_p (last_fall_p),
        .sdin        (sdin),
        .dac_left    (dac_left),
        .dac_right   (dac_right),
        .dac_valid   (dac_valid)
    );

endmodule

// File: rtl/asp_checker.sv
module asp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_mce,
    input logic        en_q,
    input logic        mono_q,
    input logic        busy,
    input logic        fsync,
    input logic        sclk,
    input logic        sdout,
    input logic [15:0] dac_left,
    input logic [15:0] dac_right,
    input logic        dac_valid
);

    // R2 / R12: two clocks of disabled state leave every serial line low
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && $past(!en_q)) |-> (!fsync && !sclk && !sdout));

    // R3: settings do not move without the configuration gate
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mce |=> ($stable(en_q) && $stable(mono_q)));

    // R4: the bit clock only runs inside a frame
    p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy);

    // R5: data moves only while the bit clock is low
    p_sdout_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout) |-> !sclk);

    // R7: frame sync only appears inside a frame
    p_fsync_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> busy);

    // R9: the received-word strobe lasts one clock
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    // R9: received words change only together with the strobe
    p_dac_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_valid |-> ($stable(dac_left) && $stable(dac_right)));

    // R10: mono returns identical words on both outputs
    p_mono_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_valid && $past(mono_q)) |-> (dac_right == dac_left));

    // R12: a strobe is only produced from an enabled port
    p_valid_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(en_q));

endmodule

bind aud_serial_port asp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mce   (cfg_mce),
    .en_q      (en_w),
    .mono_q    (mono_w),
    .busy      (frame_busy),
    .fsync     (fsync),
    .sclk      (sclk),
    .sdout     (sdout),
    .dac_left  (dac_left),
    .dac_right (dac_right),
    .dac_valid (dac_valid)
);

// File: tb/tb_aud_serial_port.sv
module tb_aud_serial_port;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mce = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [1:0]  cfg_format = 2'd0;
    logic [1:0]  cfg_size = 2'd0;
    logic        cfg_mono = 1'b0;
    logic        rate_tick = 1'b0;
    logic [15:0] adc_left = '0;
    logic [15:0] adc_right = '0;
    logic        sdin = 1'b0;
    logic        fsync, sclk, sdout, dac_valid;
    logic [15:0] dac_left, dac_right;

    int n_chk = 0;
    int n_bad = 0;

    // bench shadow of the captured settings
    logic [1:0] sh_fmt = 2'd0;
    logic [1:0] sh_size = 2'd0;
    logic       sh_mono = 1'b0;

    always #2 clk = ~clk;

    aud_serial_port #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_mce(cfg_mce), .cfg_enable(cfg_enable),
        .cfg_format(cfg_format), .cfg_size(cfg_size), .cfg_mono(cfg_mono),
        .rate_tick(rate_tick), .adc_left(adc_left), .adc_right(adc_right),
        .sdin(sdin), .fsync(fsync), .sclk(sclk), .sdout(sdout),
        .dac_left(dac_left), .dac_right(dac_right), .dac_valid(dac_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] place(input logic [1:0] sz, input logic [15:0] s);
        if (sz == 2'd1) return {s[7:0], 8'h00};
        if (sz == 2'd2) return {s[3:0], 12'h000};
        return s;
    endfunction

    function automatic logic [15:0] trim(input logic [1:0] sz, input logic [15:0] w);
        if (sz == 2'd1) return {w[15:8], 8'h00};
        if (sz == 2'd2) return {w[15:12], 12'h000};
        return w;
    endfunction

    function automatic logic [31:0] sync_pat(input logic [1:0] f);
        if (f == 2'd1) return 32'h0000_0001;
        if (f == 2'd2) return 32'h8000_0000;
        return 32'hFFFF_0000;
    endfunction

    task automatic write_cfg(input bit en, input logic [1:0] f, input logic [1:0] sz, input bit mono);
        @(negedge clk);
        cfg_enable = en; cfg_format = f; cfg_size = sz; cfg_mono = mono; cfg_mce = 1'b1;
        @(negedge clk);
        cfg_mce = 1'b0;
        sh_fmt = f; sh_size = sz; sh_mono = mono;
        // scramble the setting inputs; they must not be picked up (R3)
        cfg_enable = ~en; cfg_format = ~f; cfg_size = ~sz; cfg_mono = ~mono;
    endtask

    // One frame. Called at a negedge; with issue_tick=0 the frame has already started.
    task automatic run_frame(input logic [15:0] l, input logic [15:0] r,
                             input logic [15:0] rx_l, input logic [15:0] rx_r,
                             input bit issue_tick, input bit chain_next,
                             input logic [15:0] nl, input logic [15:0] nr,
                             input bit tick_mid, input string tag);
        logic [31:0] txw = '0;
        logic [31:0] fsw = '0;
        logic [31:0] rxw = {rx_l, rx_r};
        logic [31:0] exp_tx;
        logic [15:0] exp_l, exp_r;
        bit clk_bad = 0;
        bit sd_bad = 0;
        exp_tx = {place(sh_size, l), sh_mono ? 16'h0000 : place(sh_size, r)};
        exp_l  = trim(sh_size, rx_l);
        exp_r  = sh_mono ? exp_l : trim(sh_size, rx_r);
        if (issue_tick) begin
            adc_left = l; adc_right = r;
            rate_tick = 1'b1;
            @(negedge clk);
            rate_tick = 1'b0;
        end
        for (int b = 0; b < 32; b++) begin
            txw[31-b] = sdout;
            fsw[31-b] = fsync;
            sdin = rxw[31-b];
            for (int p = 0; p < 2*HALF; p++) begin
                if (p > 0) begin
                    if (sclk !== (p >= HALF)) clk_bad = 1;
                    if (sdout !== txw[31-b]) sd_bad = 1;
                end else if (sclk !== 1'b0) begin
                    clk_bad = 1;
                end
                if (tick_mid && b == 10 && p == 0) rate_tick = 1'b1;
                if (p == 1) rate_tick = 1'b0;
                if (chain_next && b == 31 && p == 2*HALF-1) begin
                    rate_tick = 1'b1; adc_left = nl; adc_right = nr;
                end
                @(negedge clk);
            end
        end
        rate_tick = 1'b0;
        check(txw == exp_tx, "R5 R6 R10", {tag, " sdout frame"}, txw, exp_tx);
        check(fsw == sync_pat(sh_fmt), "R7", {tag, " fsync pattern"}, fsw, sync_pat(sh_fmt));
        check(!clk_bad, "R4", {tag, " sclk shape"}, 32'(clk_bad), 32'd0);
        check(!sd_bad, "R5", {tag, " sdout stable while sclk high"}, 32'(sd_bad), 32'd0);
        check(dac_valid === 1'b1, "R9", {tag, " valid after last bit"}, 32'(dac_valid), 32'd1);
        check(dac_left === exp_l, "R8", {tag, " dac_left"}, 32'(dac_left), 32'(exp_l));
        check(dac_right === exp_r, "R8 R10", {tag, " dac_right"}, 32'(dac_right), 32'(exp_r));
        if (!chain_next) begin
            @(negedge clk);
            check(dac_valid === 1'b0, "R9", {tag, " valid one clock"}, 32'(dac_valid), 32'd0);
            check({fsync, sclk, sdout} === 3'b000, "R4", {tag, " idle lines"},
                  32'({fsync, sclk, sdout}), 32'd0);
            check(dac_left === exp_l, "R9", {tag, " dac_left held"}, 32'(dac_left), 32'(exp_l));
        end
    endtask

    task automatic t_reset;
        check({fsync, sclk, sdout, dac_valid} === 4'b0000, "R1", "reset lines",
              32'({fsync, sclk, sdout, dac_valid}), 32'd0);
        check({dac_left, dac_right} === 32'd0, "R1", "reset words", {dac_left, dac_right}, 32'd0);
    endtask

    task automatic t_disabled;
        int seen = 0;
        for (int i = 0; i < 150; i++) begin
            rate_tick = (i % 40 == 0);
            @(negedge clk);
            if (fsync || sclk || sdout || dac_valid) seen++;
        end
        rate_tick = 1'b0;
        check(seen == 0, "R2", "disabled port activity", 32'(seen), 32'd0);
    endtask

    task automatic t_cfg_gate;
        write_cfg(1'b1, 2'd0, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        // scrambled inputs would mean disabled, mono, format 3, size 3 if taken (R3)
        run_frame(16'hA5C3, 16'h1234, 16'hBEEF, 16'h0F0F, 1, 0, '0, '0, 1, "R3 gated stereo");
    endtask

    task automatic t_sizes;
        write_cfg(1'b1, 2'd2, 2'd1, 1'b0);
        run_frame(16'hFF9A, 16'h7E3C, 16'hC3FF, 16'h5AA5, 1, 0, '0, '0, 0, "R6 size8 fmt2");
        write_cfg(1'b1, 2'd1, 2'd2, 1'b0);
        run_frame(16'hFFFB, 16'h0006, 16'h9FFF, 16'h7123, 1, 0, '0, '0, 0, "R6 size4 fmt1");
        write_cfg(1'b1, 2'd3, 2'd3, 1'b0);
        run_frame(16'h8001, 16'hFFFF, 16'h0001, 16'h8000, 1, 0, '0, '0, 0, "R6 size3 fmt3");
    endtask

    task automatic t_mono;
        write_cfg(1'b1, 2'd0, 2'd0, 1'b1);
        run_frame(16'h3C5A, 16'hFFFF, 16'h6B2D, 16'hAAAA, 1, 0, '0, '0, 0, "R10 mono");
    endtask

    task automatic t_chain;
        write_cfg(1'b1, 2'd1, 2'd0, 1'b0);
        run_frame(16'h1111, 16'h2222, 16'h3333, 16'h4444, 1, 1, 16'hCAFE, 16'hD00D, 0, "R11 first");
        run_frame(16'hCAFE, 16'hD00D, 16'h5555, 16'h6666, 0, 0, '0, '0, 0, "R11 second");
    endtask

    task automatic t_abort;
        int seen = 0;
        write_cfg(1'b1, 2'd0, 2'd0, 1'b0);
        adc_left = 16'hFFFF; adc_right = 16'hFFFF;
        rate_tick = 1'b1;
        @(negedge clk);
        rate_tick = 1'b0;
        repeat (40) @(negedge clk);
        cfg_enable = 1'b0; cfg_mce = 1'b1;
        @(negedge clk);
        cfg_mce = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({fsync, sclk, sdout} === 3'b000, "R12", "lines after abort",
              32'({fsync, sclk, sdout}), 32'd0);
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (dac_valid || sclk) seen++;
        end
        check(seen == 0, "R12", "no strobe after abort", 32'(seen), 32'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_cfg_gate();
        t_sizes();
        t_mono();
        t_chain();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule